// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Guard

This block sits between the external bus of an 8-bit microcontroller and a register file inside programmable logic. The host puts the low address byte on a shared eight-bit bus while the address-latch strobe is high. It presents further address bits on a separate high port, then moves data over the same shared bus under active-low read and write strobes. All three strobes are sampled on the system clock through synchronizer chains, and edges are found from those samples. The strobes never act as clocks.

The block keeps an address-valid flag. The flag is set only by the falling edge of the address latch. A read or write strobe that begins while the flag is clear is ignored, and every accepted data phase clears the flag when it ends. A host that comes out of reset or powers up at a different moment from the logic may issue stray strobes, but these never reach the register file or the shared bus. The next complete address phase puts the block back in step, and no reset of the logic is needed. Toward the register file the block offers a 16-bit address, a one-cycle write strobe with data, and a one-cycle read request whose returned data is captured one clock later.

Top module: `mux_bus_guard`

## Requirements
- R1: After reset the bus output enable, the write strobe and the read request toward the register file are all low.
- R2: At each detected falling edge of the address latch, the register address becomes {high port bit 5, 0, 0, high port bits 4..0, shared bus byte}, using the values sampled while the latch was still high.
- R3: After an address phase, a high-to-low-to-high pulse on the write strobe produces exactly one one-cycle register write. The write carries the latched address and the shared bus value sampled on the last clock before the rise was detected.
- R4: After an address phase, a falling read strobe produces exactly one one-cycle read request. From the following cycle the block drives the returned data onto the shared bus while the read strobe stays low.
- R5: The shared bus output enable is low whenever the read strobe is high or the write strobe is low, so it drops in the same instant that the read strobe rises.
- R6: Once an accepted read or write has completed, a further data strobe with no new address phase causes no register write, no read request and no bus drive.
- R7: A read or write strobe that arrives with no address phase since reset is ignored.
- R8: When read and write are both seen low together, no access occurs and the address-valid flag is cleared. A later strobe then has no effect until a new address phase.
- R9: After stray strobes from a host that was reset or powered on out of step, the next full address and data cycle completes correctly without any reset of the logic.
- R10: Write data changing in the same instant that the write strobe rises does not change the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low logic reset |
| bus_ale | input | 1 | Address latch strobe from host, active high |
| bus_rd_n | input | 1 | Read strobe from host, active low |
| bus_wr_n | input | 1 | Write strobe from host, active low |
| bus_hi | input | 6 | High address port from host |
| bus_ad_in | input | 8 | Shared address/data bus, input side |
| bus_ad_out | output | 8 | Shared bus read data, output side |
| bus_ad_oe | output | 1 | Output enable for the shared bus pad |
| reg_addr | output | 16 | Latched register address |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd_req | output | 1 | One-cycle register read request |
| reg_rdata | input | 8 | Register read data, valid the cycle after the request |

## Verification
The bench builds the block with its default two-stage synchronizer and an eight-bit data width. With that depth an edge is detected exactly three clocks after the pin moves, so each strobe phase of five or more clocks lets the bench check acceptance, bus drive and the captured data at known cycles. The register file model returns the XOR of the two address bytes. Every read therefore checks the address formation and the data path together, including the two forced-zero address bits.

// File: rtl/mux_bus_guard.sv
module mux_bus_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int HI_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ale,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [HI_W-1:0]   bus_hi,
  input  logic [DATA_W-1:0] bus_ad_in,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  output logic [15:0]       reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_req,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int N = SYNC_STAGES + 1;

  logic [N-1:0]      ale_p, rd_p, wr_p;
  logic [DATA_W-1:0] ad_p [N];
  logic [HI_W-1:0]   hi_p [N];
  logic addr_vld, rd_act, wr_act, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_p <= '0;
      rd_p  <= '1;
      wr_p  <= '1;
    end else begin
      ale_p <= {ale_p[N-2:0], bus_ale};
      rd_p  <= {rd_p[N-2:0], bus_rd_n};
      wr_p  <= {wr_p[N-2:0], bus_wr_n};
    end
  end

  always_ff @(posedge clk) begin
    ad_p[0] <= bus_ad_in;
    hi_p[0] <= bus_hi;
    for (int i = 1; i < N; i++) begin
      ad_p[i] <= ad_p[i-1];
      hi_p[i] <= hi_p[i-1];
    end
  end

  wire ale_fall = ale_p[N-1] & ~ale_p[N-2];
  wire rd_fall  = rd_p[N-1] & ~rd_p[N-2];
  wire rd_rise  = ~rd_p[N-1] & rd_p[N-2];
  wire wr_fall  = wr_p[N-1] & ~wr_p[N-2];
  wire wr_rise  = ~wr_p[N-1] & wr_p[N-2];
  wire bus_err  = ~rd_p[N-2] & ~wr_p[N-2];
  wire idle     = ~rd_act & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_vld   <= 1'b0;
      rd_act     <= 1'b0;
      wr_act     <= 1'b0;
      oe_q       <= 1'b0;
      reg_addr   <= '0;
      reg_wr_en  <= 1'b0;
      reg_wdata  <= '0;
      reg_rd_req <= 1'b0;
      bus_ad_out <= '0;
    end else begin
      reg_wr_en  <= 1'b0;
      reg_rd_req <= 1'b0;
      if (bus_err) begin
        addr_vld <= 1'b0;
        rd_act   <= 1'b0;
        wr_act   <= 1'b0;
        oe_q     <= 1'b0;
      end else if (ale_fall) begin
        reg_addr <= {hi_p[N-1][5], 2'b00, hi_p[N-1][4:0], ad_p[N-1]};
        addr_vld <= 1'b1;
        rd_act   <= 1'b0;
        wr_act   <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        if (reg_rd_req && rd_act) begin
          bus_ad_out <= reg_rdata;
          oe_q       <= 1'b1;
        end
        if (rd_fall && addr_vld && idle) begin
          rd_act     <= 1'b1;
          reg_rd_req <= 1'b1;
        end else if (rd_rise && rd_act) begin
          rd_act   <= 1'b0;
          oe_q     <= 1'b0;
          addr_vld <= 1'b0;
        end
        if (wr_fall && addr_vld && idle) begin
          wr_act <= 1'b1;
        end else if (wr_rise && wr_act) begin
          wr_act    <= 1'b0;
          reg_wr_en <= 1'b1;
          reg_wdata <= ad_p[N-1];
          addr_vld  <= 1'b0;
        end
      end
    end
  end

  assign bus_ad_oe = oe_q & ~bus_rd_n & bus_wr_n;

endmodule

module mux_bus_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_ad_oe,
  input logic reg_wr_en,
  input logic reg_rd_req,
  input logic addr_vld,
  input logic bus_err
);
  assert_oe_off_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> !bus_ad_oe);
  assert_oe_off_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n |-> !bus_ad_oe);
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> !reg_rd_req);
  assert_wr_needs_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(addr_vld));
  assert_rd_needs_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |-> $past(addr_vld));
  assert_err_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (!addr_vld && !reg_wr_en && !reg_rd_req));
endmodule

bind mux_bus_guard mux_bus_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_ad_oe(bus_ad_oe), .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
  .addr_vld(addr_vld), .bus_err(bus_err)
);

// File: tb/mux_bus_guard_tb_top.sv
module mux_bus_guard_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_ale = 0, bus_rd_n = 1, bus_wr_n = 1;
  logic [5:0] bus_hi = '0;
  logic [7:0] bus_ad_in = '0;
  logic [7:0] bus_ad_out, reg_wdata, reg_rdata;
  logic bus_ad_oe, reg_wr_en, reg_rd_req;
  logic [15:0] reg_addr;

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_seen = 0;
  logic [15:0] last_wa;
  logic [7:0]  last_wd;

  always #5 clk = ~clk;

  mux_bus_guard dut_i (
    .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_hi(bus_hi), .bus_ad_in(bus_ad_in),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_req(reg_rd_req),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = reg_addr[7:0] ^ reg_addr[15:8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_wr_en) begin wr_cnt <= wr_cnt + 1; last_wa <= reg_addr; last_wd <= reg_wdata; end
    if (reg_rd_req) rd_cnt <= rd_cnt + 1;
    if (bus_ad_oe) oe_seen <= oe_seen + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [5:0] hi, input logic [7:0] lo);
    bus_hi = hi; bus_ad_in = lo; bus_ale = 1; clks(5);
    bus_ale = 0; clks(2);
    bus_ad_in = 8'hC3; clks(4);
  endtask

  task automatic write_phase(input logic [7:0] d);
    bus_ad_in = d; bus_wr_n = 0; clks(6);
    bus_wr_n = 1; bus_ad_in = ~d; clks(6);
  endtask

  task automatic read_phase(output logic [7:0] d, output logic oe);
    bus_ad_in = 8'h00; bus_rd_n = 0; clks(7);
    d = bus_ad_out; oe = bus_ad_oe;
    bus_rd_n = 1; #1;
    check("R5 oe drops with read high", bus_ad_oe, 0);
    clks(6);
  endtask

  task automatic t_reset;
    check("R1 oe", bus_ad_oe, 0);
    check("R1 wr_en", reg_wr_en, 0);
    check("R1 rd_req", reg_rd_req, 0);
  endtask

  task automatic t_stray_at_start;
    logic [7:0] d; logic oe;
    write_phase(8'h11);
    read_phase(d, oe);
    check("R7 no write before address", wr_cnt, 0);
    check("R7 no read before address", rd_cnt, 0);
    check("R7 no drive before address", oe_seen, 0);
  endtask

  task automatic t_write;
    int w0 = wr_cnt;
    addr_phase(6'h25, 8'h3C);
    check("R2 address formation", reg_addr, 16'h853C);
    write_phase(8'hA7);
    check("R3 one write", wr_cnt - w0, 1);
    check("R3 write address", last_wa, 16'h853C);
    check("R10 data held through rise", last_wd, 8'hA7);
  endtask

  task automatic t_read;
    logic [7:0] d; logic oe; int r0 = rd_cnt;
    addr_phase(6'h1F, 8'h40);
    check("R2 zero bits 14:13", reg_addr, 16'h1F40);
    read_phase(d, oe);
    check("R4 one read request", rd_cnt - r0, 1);
    check("R4 bus driven", oe, 1);
    check("R4 read data", d, 8'h5F);
  endtask

  task automatic t_no_readdress;
    logic [7:0] d; logic oe; int w0, r0, o0;
    addr_phase(6'h00, 8'h05);
    write_phase(8'h66);
    w0 = wr_cnt; r0 = rd_cnt; o0 = oe_seen;
    write_phase(8'h77);
    read_phase(d, oe);
    check("R6 second write ignored", wr_cnt, w0);
    check("R6 second read ignored", rd_cnt, r0);
    check("R6 no bus drive", oe_seen, o0);
    check("R6 data kept", last_wd, 8'h66);
  endtask

  task automatic t_bus_err;
    int w0, r0;
    addr_phase(6'h20, 8'h99);
    w0 = wr_cnt; r0 = rd_cnt;
    bus_ad_in = 8'h12; bus_wr_n = 0; bus_rd_n = 0; clks(6);
    bus_wr_n = 1; bus_rd_n = 1; clks(6);
    check("R8 no write on conflict", wr_cnt, w0);
    write_phase(8'h34);
    check("R8 flag cleared", wr_cnt, w0);
    check("R8 no read request", rd_cnt - r0, 0);
  endtask

  task automatic t_recover;
    logic [7:0] d; logic oe; int w0;
    addr_phase(6'h03, 8'h10);
    bus_rd_n = 0; clks(4);
    bus_rd_n = 1; clks(4);
    w0 = wr_cnt;
    write_phase(8'hEE);
    check("R9 stray write after host reset ignored", wr_cnt, w0);
    addr_phase(6'h21, 8'h81);
    write_phase(8'h5A);
    check("R9 recovered write", wr_cnt - w0, 1);
    check("R9 recovered address", last_wa, 16'h8181);
    check("R9 recovered data", last_wd, 8'h5A);
    addr_phase(6'h21, 8'h81);
    read_phase(d, oe);
    check("R9 recovered read", d, 8'h00);
  endtask

  initial begin
    clks(3);
    t_reset;
    rst_n = 1; clks(3);
    t_reset;
    t_stray_at_start;
    t_write;
    t_read;
    t_no_readdress;
    t_bus_err;
    t_recover;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule